// File: doc/BRIEF.md
# Complementary Pin-Pair Router with Dead-Time Insertion

This block sits between two free-running pulse-width generators and a half-bridge style output pin pair (a high-side pin and a low-side pin). A mode input chooses how the pair is driven. In independent operation each pin copies its own generator through one register stage. In complementary operation one generator, chosen by a select input, drives both pins. The high-side pin carries the chosen signal and the low-side pin carries its inverse.

In complementary operation, every edge of the chosen signal loads an 8-bit down-counter with the programmed dead-time. The pin that is switching off drops in the same cycle. The pin that is switching on is held inactive until the counter has run down to zero, so the two pins are never active together. The counter advances once per system clock. Generating the pulse trains themselves is left to the generators that feed this block.

Top module: `pwm_pair_router`

## Requirements
- R1: While `rst_n` is low, both `hi_o` and `lo_o` are 0 whatever the other inputs are. Reset leaves the block in independent mode, and the mode register clears to 0.
- R2: With `comp_mode_i` = 0 (independent), `hi_o` equals `pwm_a_i` and `lo_o` equals `pwm_b_i` one clock after they are sampled. Both pins may be 1 together, and no dead-time is applied.
- R3: With `comp_mode_i` = 1 and `src_sel_i` = 0, the pair is taken from `pwm_a_i`: `hi_o` follows it and `lo_o` follows its inverse. `pwm_b_i` has no effect on either pin.
- R4: With `comp_mode_i` = 1 and `src_sel_i` = 1, the pair is taken from `pwm_b_i`, and `pwm_a_i` has no effect on either pin.
- R5: In complementary mode `hi_o` and `lo_o` are never both 1.
- R6: On a rising edge of the chosen signal with dead-time D, `lo_o` goes to 0 at once, in the first cycle after the edge is sampled. `hi_o` then stays 0 for D cycles and goes to 1 after D+1 clocks.
- R7: On a falling edge with dead-time D, `hi_o` goes to 0 at once and `lo_o` goes to 1 after D+1 clocks.
- R8: A dead-time of 0 gives plain complementary outputs: the pins change one clock after the edge is sampled, with no gap.
- R9: An edge that arrives while the counter is still running reloads the counter. Both pins then stay 0 until the reloaded count reaches 0.
- R10: The dead-time value is captured when an edge is seen. Changing `dead_cnt_i` during a count does not alter the count that is running. Every value from 0 to 255 is honoured, including 255.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; the dead-time counter ticks on it |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| pwm_a_i | input | 1 | Raw pulse train from generator 0 |
| pwm_b_i | input | 1 | Raw pulse train from generator 1 |
| comp_mode_i | input | 1 | 0 = independent, 1 = complementary |
| src_sel_i | input | 1 | Complementary source: 0 = generator 0, 1 = generator 1 |
| dead_cnt_i | input | 8 | Dead-time length in clock cycles |
| hi_o | output | 1 | High-side pin |
| lo_o | output | 1 | Low-side pin |

## Verification
The bound checker watches several behaviours on every cycle:
- the two pins are never active together in complementary mode;
- the pins stay low during reset;
- in independent mode the high-side pin copies generator 0 with one cycle of delay;
- every edge loads the counter with the programmed value;
- the counter steps down by exactly one when no edge is seen.

The length of the gap before a pin turns on, the reload of the counter on an edge that arrives mid-count, the largest dead-time and the ignored generator can only be shown by the bench's directed scenarios. Those scenarios count cycles and compare the pin levels with values worked out from the requirements.

// File: rtl/pwm_pair_pkg.sv
package pwm_pair_pkg;

  localparam int unsigned DT_W_DEF = 8;

  typedef enum logic {
    ROUTE_INDEP = 1'b0,
    ROUTE_COMP  = 1'b1
  } route_mode_e;

  typedef enum logic {
    SRC_GEN0 = 1'b0,
    SRC_GEN1 = 1'b1
  } route_src_e;

  typedef struct packed {
    logic hi;
    logic lo;
  } pin_pair_t;

endpackage

// File: rtl/pwm_src_select.sv
module pwm_src_select
  import pwm_pair_pkg::*;
(
  input  logic       gen0_i,
  input  logic       gen1_i,
  input  route_src_e src_i,
  output logic       chosen_o
);

  always_comb begin
    unique case (src_i)
      SRC_GEN1: chosen_o = gen1_i;
      default:  chosen_o = gen0_i;
    endcase
  end

endmodule

// File: rtl/pwm_edge_tracker.sv
module pwm_edge_tracker (
  input  logic clk,
  input  logic rst_n,
  input  logic sig_i,
  output logic level_o,
  output logic edge_o
);

  logic level_q;
  logic level_d;
  logic level_en;
  logic rise;
  logic fall;

  // Edge detection against the last sampled level.
  always_comb begin
    rise     = sig_i & ~level_q;
    fall     = ~sig_i & level_q;
    level_en = rise | fall;
    level_d  = sig_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_q <= 1'b0;
    end else if (level_en) begin
      level_q <= level_d;
    end
  end

  assign level_o = level_q;
  assign edge_o  = rise | fall;

endmodule

// File: rtl/pwm_dead_counter.sv
module pwm_dead_counter #(
  parameter int unsigned DT_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load_i,
  input  logic [DT_W-1:0] load_val_i,
  output logic [DT_W-1:0] cnt_o,
  output logic            idle_o
);

  localparam logic [DT_W-1:0] CNT_ONE  = DT_W'(1);
  localparam logic [DT_W-1:0] CNT_ZERO = '0;

  logic [DT_W-1:0] cnt_q;
  logic [DT_W-1:0] cnt_d;
  logic            cnt_en;

  // A new edge always reloads the counter; otherwise it steps down to zero.
  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (load_i) begin
      cnt_en = 1'b1;
      cnt_d  = load_val_i;
    end else if (cnt_q != CNT_ZERO) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q - CNT_ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= CNT_ZERO;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt_o  = cnt_q;
  assign idle_o = (cnt_q == CNT_ZERO);

endmodule

// File: rtl/pwm_pin_driver.sv
module pwm_pin_driver
  import pwm_pair_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        gen0_i,
  input  logic        gen1_i,
  input  route_mode_e mode_i,
  input  logic        level_i,
  input  logic        idle_i,
  output route_mode_e mode_o,
  output pin_pair_t   pins_o
);

  route_mode_e mode_q;
  logic        gen0_q;
  logic        gen1_q;
  pin_pair_t   pins;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= ROUTE_INDEP;
      gen0_q <= 1'b0;
      gen1_q <= 1'b0;
    end else begin
      mode_q <= mode_i;
      gen0_q <= gen0_i;
      gen1_q <= gen1_i;
    end
  end

  // Both complementary pins are gated by the idle counter: the pin
  // turning off drops at once, the one turning on waits for zero.
  always_comb begin
    unique case (mode_q)
      ROUTE_COMP: begin
        pins.hi = level_i & idle_i;
        pins.lo = ~level_i & idle_i;
      end
      default: begin
        pins.hi = gen0_q;
        pins.lo = gen1_q;
      end
    endcase
  end

  assign mode_o = mode_q;
  assign pins_o = pins;

endmodule

// File: rtl/pwm_pair_router.sv
module pwm_pair_router
  import pwm_pair_pkg::*;
#(
  parameter int unsigned DT_W = DT_W_DEF
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            pwm_a_i,
  input  logic            pwm_b_i,
  input  logic            comp_mode_i,
  input  logic            src_sel_i,
  input  logic [DT_W-1:0] dead_cnt_i,
  output logic            hi_o,
  output logic            lo_o
);

  logic            chosen;
  logic            level_q;
  logic            edge_any;
  logic [DT_W-1:0] cnt_q;
  logic            cnt_idle;
  route_mode_e     mode_q;
  pin_pair_t       pins;

  pwm_src_select u_sel (
    .gen0_i   (pwm_a_i),
    .gen1_i   (pwm_b_i),
    .src_i    (route_src_e'(src_sel_i)),
    .chosen_o (chosen)
  );

  pwm_edge_tracker u_edge (
    .clk     (clk),
    .rst_n   (rst_n),
    .sig_i   (chosen),
    .level_o (level_q),
    .edge_o  (edge_any)
  );

  pwm_dead_counter #(.DT_W(DT_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (edge_any),
    .load_val_i (dead_cnt_i),
    .cnt_o      (cnt_q),
    .idle_o     (cnt_idle)
  );

  pwm_pin_driver u_drv (
    .clk     (clk),
    .rst_n   (rst_n),
    .gen0_i  (pwm_a_i),
    .gen1_i  (pwm_b_i),
    .mode_i  (route_mode_e'(comp_mode_i)),
    .level_i (level_q),
    .idle_i  (cnt_idle),
    .mode_o  (mode_q),
    .pins_o  (pins)
  );

  assign hi_o = pins.hi;
  assign lo_o = pins.lo;

endmodule

// File: rtl/pwm_pair_router_chk.sv
module pwm_pair_router_chk
  import pwm_pair_pkg::*;
#(
  parameter int unsigned DT_W = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            pwm_a_i,
  input logic [DT_W-1:0] dead_cnt_i,
  input logic            hi_o,
  input logic            lo_o,
  input route_mode_e     mode_q,
  input logic            edge_any,
  input logic [DT_W-1:0] cnt_q
);

  // R1
  always @(posedge clk) begin
    if (!rst_n) begin
      reset_pins_low_chk: assert (!hi_o && !lo_o);
    end
  end

  // R5
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == ROUTE_COMP) |-> !(hi_o && lo_o));

  // R2
  indep_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && mode_q == ROUTE_INDEP) |-> (hi_o == $past(pwm_a_i)));

  // R10
  edge_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    edge_any |=> (cnt_q == $past(dead_cnt_i)));

  // R6
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != '0 && !edge_any) |=> (cnt_q == $past(cnt_q) - DT_W'(1)));

endmodule

bind pwm_pair_router pwm_pair_router_chk #(.DT_W(DT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .pwm_a_i    (pwm_a_i),
  .dead_cnt_i (dead_cnt_i),
  .hi_o       (hi_o),
  .lo_o       (lo_o),
  .mode_q     (mode_q),
  .edge_any   (edge_any),
  .cnt_q      (cnt_q)
);

// File: tb/pwm_pair_router_bench.sv
`timescale 1ns/1ps
module pwm_pair_router_bench;

  logic       clk;
  logic       rst_n;
  logic       pwm_a_i;
  logic       pwm_b_i;
  logic       comp_mode_i;
  logic       src_sel_i;
  logic [7:0] dead_cnt_i;
  logic       hi_o;
  logic       lo_o;

  int checks;
  int errors;

  pwm_pair_router u_pwm_pair_router (
    .clk         (clk),
    .rst_n       (rst_n),
    .pwm_a_i     (pwm_a_i),
    .pwm_b_i     (pwm_b_i),
    .comp_mode_i (comp_mode_i),
    .src_sel_i   (src_sel_i),
    .dead_cnt_i  (dead_cnt_i),
    .hi_o        (hi_o),
    .lo_o        (lo_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // {mode, sel, a, b, exp_hi, exp_lo}, dead-time 0
  localparam int NV = 12;
  localparam logic [5:0] VEC [NV] = '{
    6'b00_10_10, // R2
    6'b00_01_01, // R2
    6'b01_11_11, // R2 both active
    6'b00_00_00, // R2
    6'b10_10_10, // R3
    6'b10_11_10, // R3 gen1 ignored
    6'b10_01_01, // R3
    6'b11_01_10, // R4
    6'b11_11_10, // R4 gen0 ignored
    6'b11_10_01, // R4
    6'b11_00_01, // R4
    6'b01_10_10  // R2
  };

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic eh, input logic el);
    checks++;
    if (hi_o !== eh || lo_o !== el) begin
      errors++;
      $display("FAIL %s: hi/lo = %b%b, expected %b%b at %0t",
               req, hi_o, lo_o, eh, el, $time);
    end
  endtask

  task automatic settle(input logic m, input logic s, input logic a, input logic b);
    comp_mode_i = m; src_sel_i = s; pwm_a_i = a; pwm_b_i = b;
    dead_cnt_i = 8'd0;
    step(); step();
  endtask

  initial begin
    #4_000_000;
    errors++;
    checks++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    checks = 0;
    errors = 0;
    rst_n = 1'b0;
    pwm_a_i = 1'b1; pwm_b_i = 1'b1; comp_mode_i = 1'b1; src_sel_i = 1'b0;
    dead_cnt_i = 8'd0;
    step(); step();
    check("R1 reset", 1'b0, 1'b0);
    pwm_a_i = 1'b0; pwm_b_i = 1'b0; comp_mode_i = 1'b0;
    rst_n = 1'b1;
    step();
    check("R1 after release", 1'b0, 1'b0);

    // vector table, one vector per clock
    for (int i = 0; i < NV; i++) begin
      comp_mode_i = VEC[i][5];
      src_sel_i   = VEC[i][4];
      pwm_a_i     = VEC[i][3];
      pwm_b_i     = VEC[i][2];
      dead_cnt_i  = 8'd0;
      step();
      check($sformatf("R2/R3/R4 vector %0d", i), VEC[i][1], VEC[i][0]);
    end

    // R6: rising edge, dead-time 3
    settle(1'b1, 1'b0, 1'b0, 1'b0);
    check("R6 setup", 1'b0, 1'b1);
    pwm_a_i = 1'b1; dead_cnt_i = 8'd3;
    for (int k = 0; k < 3; k++) begin
      step();
      check("R6 gap", 1'b0, 1'b0);
    end
    step();
    check("R6 hi on", 1'b1, 1'b0);

    // R7 + R10: falling edge, dead-time 2, value changed mid-count
    pwm_a_i = 1'b0; dead_cnt_i = 8'd2;
    step();
    check("R7 hi off at once", 1'b0, 1'b0);
    dead_cnt_i = 8'd9;
    step();
    check("R7 gap", 1'b0, 1'b0);
    step();
    check("R10 lo on after captured count", 1'b0, 1'b1);

    // R9: reload mid-count
    settle(1'b1, 1'b0, 1'b0, 1'b0);
    pwm_a_i = 1'b1; dead_cnt_i = 8'd4;
    step(); step();
    pwm_a_i = 1'b0;
    for (int k = 0; k < 4; k++) begin
      step();
      check("R9 both off after reload", 1'b0, 1'b0);
    end
    step();
    check("R9 lo on", 1'b0, 1'b1);

    // R8: zero dead-time, source gen1
    settle(1'b1, 1'b1, 1'b0, 1'b0);
    pwm_b_i = 1'b1;
    step();
    check("R8 no gap rise", 1'b1, 1'b0);
    pwm_b_i = 1'b0;
    step();
    check("R8 no gap fall", 1'b0, 1'b1);

    // R4: gen0 toggling has no effect with sel=1
    pwm_a_i = 1'b1; dead_cnt_i = 8'd5;
    step(); step();
    check("R4 gen0 ignored", 1'b0, 1'b1);

    // R10: largest dead-time
    settle(1'b1, 1'b0, 1'b0, 1'b0);
    pwm_a_i = 1'b1; dead_cnt_i = 8'd255;
    for (int k = 0; k < 255; k++) step();
    check("R10 255 still off", 1'b0, 1'b0);
    step();
    check("R10 255 hi on", 1'b1, 1'b0);

    // R1: reset mid-operation
    rst_n = 1'b0;
    #1;
    check("R1 async reset", 1'b0, 1'b0);
    step();
    rst_n = 1'b1;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule